// File: doc/BRIEF.md
# Dual-Queue Slice-Aware Micro-Op Issue Unit

This block sits between rename and execution in a core that overlaps address-generating instruction chains with memory latency. Renamed micro-ops arrive one per cycle in program order. Each carries two source tags, one destination tag, a load marker and a marker saying it belongs to an address-computing slice. The unit holds one "waits-on-memory" bit per register. Any micro-op that reads a register with this bit set joins a second in-order queue. All other micro-ops join the first queue. A chain stalled behind a missing load therefore cannot hold up independent work.

Each queue issues only from its head, and each has its own valid/ready port to execution. A head leaves when both of its source registers are marked ready in a scoreboard and its port accepts. The scoreboard clears a register's ready bit when a producer is dispatched. It sets the bit again on a writeback broadcast or a load-completion report for that tag, and either report also clears the register's waits-on-memory bit. A synchronous flush empties both queues and clears every waits-on-memory bit.

Top module: `slice_issue_unit`

## Requirements
- R1: After reset both queues are empty, neither issue port shows valid, and dispatch ready is high.
- R2: A dispatched micro-op whose source 0 or source 1 register has its waits-on-memory bit set goes to the dependent queue (issued on the `dep_*` port). Every other micro-op goes to the independent queue (issued on the `ind_*` port). At most one micro-op is accepted per cycle. Steering uses the bit values held before the dispatch edge.
- R3: Dispatching a load, or dispatching any micro-op into the dependent queue, sets the waits-on-memory bit of its destination. A writeback broadcast or load-completion report naming that tag clears the bit.
- R4: A queue head shows valid on its port only when both of its source registers are ready. Dispatch makes the destination not ready. A writeback or load-completion report makes it ready, and the head can issue from the next cycle.
- R5: Inside one queue, micro-ops issue strictly in the order they were dispatched.
- R6: An independent micro-op issues even while the dependent queue's head is stalled on a missing operand.
- R7: When both heads are issuable and both ports are ready, both issue in the same cycle.
- R8: Each queue holds 8 entries. Dispatch ready is low while the queue the current micro-op would enter is full, and the micro-op is not taken. Dispatch to the other queue is still taken.
- R9: While flush is high, dispatch ready is low. After the flush edge, both queues are empty and every waits-on-memory bit is clear.
- R10: While a port shows valid and its ready is low, the port stays valid with unchanged fields. The issued fields equal the dispatched source tags, destination tag, load marker and slice marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous flush of both queues and all waits-on-memory bits |
| disp_valid | input | 1 | Dispatch micro-op present |
| disp_ready | output | 1 | Dispatch accepted this cycle when valid |
| disp_src0 | input | TAG_W | First source register tag |
| disp_src1 | input | TAG_W | Second source register tag |
| disp_dst | input | TAG_W | Destination register tag |
| disp_is_load | input | 1 | Micro-op is a load |
| disp_slice | input | 1 | Micro-op belongs to an address-generating slice |
| wb_valid | input | 1 | Writeback broadcast present |
| wb_tag | input | TAG_W | Tag written back |
| ldc_valid | input | 1 | Load completion present |
| ldc_tag | input | TAG_W | Tag of the completed load |
| ind_valid | output | 1 | Independent queue head issuable |
| ind_ready | input | 1 | Independent execution port accepts |
| ind_src0 | output | TAG_W | Issued first source |
| ind_src1 | output | TAG_W | Issued second source |
| ind_dst | output | TAG_W | Issued destination |
| ind_is_load | output | 1 | Issued load marker |
| ind_slice | output | 1 | Issued slice marker |
| dep_valid | output | 1 | Dependent queue head issuable |
| dep_ready | input | 1 | Dependent execution port accepts |
| dep_src0 | output | TAG_W | Issued first source |
| dep_src1 | output | TAG_W | Issued second source |
| dep_dst | output | TAG_W | Issued destination |
| dep_is_load | output | 1 | Issued load marker |
| dep_slice | output | 1 | Issued slice marker |

## Verification
Some properties are checked on every cycle: that no queue is pushed when full or popped when empty, that at most one queue takes a micro-op per cycle, that flush leaves the queues empty and the waits-on-memory bits clear, that a stalled port holds its payload, and that a writeback makes its tag ready. Other behaviour can only be shown by the bench's scenarios. This includes which queue a given dependence pattern selects, that an independent chain overtakes a stalled dependent one, issue order within a queue, that both ports issue together, and that a full target queue blocks dispatch while the other queue still accepts.

// File: rtl/slq_pkg.sv
package slq_pkg;

  localparam int NUM_Q = 2;

  typedef enum logic {
    Q_IND = 1'b0,
    Q_DEP = 1'b1
  } qsel_e;

endpackage

// File: rtl/slq_fifo.sv
module slq_fifo #(
  parameter int WIDTH = 17,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             head_valid,
  output logic [WIDTH-1:0] head_data,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] rd_ptr, rd_ptr_n;
  logic [PTR_W-1:0] wr_ptr, wr_ptr_n;
  logic [CNT_W-1:0] count, count_n;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_ptr_n = rd_ptr;
    wr_ptr_n = wr_ptr;
    count_n  = count;
    if (flush) begin
      rd_ptr_n = '0;
      wr_ptr_n = '0;
      count_n  = '0;
    end else begin
      if (push) wr_ptr_n = bump(wr_ptr);
      if (pop)  rd_ptr_n = bump(rd_ptr);
      if (push && !pop)      count_n = count + 1'b1;
      else if (pop && !push) count_n = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_n;
      wr_ptr <= wr_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) store[wr_ptr] <= push_data;
  end

  assign head_valid = (count != '0);
  assign head_data  = store[rd_ptr];
  assign full       = (count == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !head_valid); // R9

endmodule

// File: rtl/slq_track.sv
module slq_track #(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                disp_fire,
  input  logic [TAG_W-1:0]    disp_dst,
  input  logic                disp_mark,
  input  logic                wb_valid,
  input  logic [TAG_W-1:0]    wb_tag,
  input  logic                ldc_valid,
  input  logic [TAG_W-1:0]    ldc_tag,
  output logic [NUM_REGS-1:0] rdy,
  output logic [NUM_REGS-1:0] mem_wait
);

  logic [NUM_REGS-1:0] rdy_n, wait_n;

  always_comb begin
    rdy_n  = rdy;
    wait_n = mem_wait;
    if (wb_valid) begin
      rdy_n[wb_tag]  = 1'b1;
      wait_n[wb_tag] = 1'b0;
    end
    if (ldc_valid) begin
      rdy_n[ldc_tag]  = 1'b1;
      wait_n[ldc_tag] = 1'b0;
    end
    if (disp_fire) begin
      rdy_n[disp_dst]  = 1'b0;
      wait_n[disp_dst] = disp_mark;
    end
    if (flush) wait_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy      <= '1;
      mem_wait <= '0;
    end else begin
      rdy      <= rdy_n;
      mem_wait <= wait_n;
    end
  end

  AST_FLUSH_CLEARS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (mem_wait == '0)); // R9
  AST_WB_MAKES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(disp_fire && disp_dst == wb_tag)) |=> rdy[$past(wb_tag)]); // R4

endmodule

// File: rtl/slq_port.sv
module slq_port #(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 5
) (
  input  logic                head_valid,
  input  logic [TAG_W-1:0]    head_src0,
  input  logic [TAG_W-1:0]    head_src1,
  input  logic [NUM_REGS-1:0] rdy,
  input  logic                port_ready,
  output logic                iss_valid,
  output logic                pop
);

  logic ops_ready;

  always_comb begin
    ops_ready = rdy[head_src0] && rdy[head_src1];
    iss_valid = head_valid && ops_ready;
    pop       = iss_valid && port_ready;
  end

endmodule

// File: rtl/slice_issue_unit.sv
module slice_issue_unit
  import slq_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int QDEPTH   = 8,
  localparam int TAG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic [TAG_W-1:0] disp_src0,
  input  logic [TAG_W-1:0] disp_src1,
  input  logic [TAG_W-1:0] disp_dst,
  input  logic             disp_is_load,
  input  logic             disp_slice,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic             ldc_valid,
  input  logic [TAG_W-1:0] ldc_tag,
  output logic             ind_valid,
  input  logic             ind_ready,
  output logic [TAG_W-1:0] ind_src0,
  output logic [TAG_W-1:0] ind_src1,
  output logic [TAG_W-1:0] ind_dst,
  output logic             ind_is_load,
  output logic             ind_slice,
  output logic             dep_valid,
  input  logic             dep_ready,
  output logic [TAG_W-1:0] dep_src0,
  output logic [TAG_W-1:0] dep_src1,
  output logic [TAG_W-1:0] dep_dst,
  output logic             dep_is_load,
  output logic             dep_slice
);

  // Packed micro-op: {slice, is_load, dst, src1, src0}
  localparam int UOP_W = 3 * TAG_W + 2;
  localparam int S0_LO = 0;
  localparam int S1_LO = TAG_W;
  localparam int DS_LO = 2 * TAG_W;
  localparam int LD_B  = 3 * TAG_W;
  localparam int SL_B  = 3 * TAG_W + 1;

  logic [NUM_REGS-1:0] rdy, mem_wait;
  logic [NUM_Q-1:0]    q_push, q_pop, q_full, q_hvalid, q_iss, q_prdy;
  logic [UOP_W-1:0]    q_hdata [NUM_Q];
  logic [UOP_W-1:0]    disp_uop;
  logic                wait_hit, tgt_full, disp_fire;

  // Steering on the registered waits-on-memory bits
  always_comb begin
    wait_hit  = mem_wait[disp_src0] || mem_wait[disp_src1];
    tgt_full  = wait_hit ? q_full[Q_DEP] : q_full[Q_IND];
    disp_ready = !flush && !tgt_full;
    disp_fire = disp_valid && disp_ready;
    q_push    = '0;
    q_push[Q_IND] = disp_fire && !wait_hit;
    q_push[Q_DEP] = disp_fire && wait_hit;
    disp_uop  = {disp_slice, disp_is_load, disp_dst, disp_src1, disp_src0};
  end

  assign q_prdy[Q_IND] = ind_ready;
  assign q_prdy[Q_DEP] = dep_ready;

  slq_track #(
    .NUM_REGS (NUM_REGS),
    .TAG_W    (TAG_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .disp_fire (disp_fire),
    .disp_dst  (disp_dst),
    .disp_mark (disp_is_load || wait_hit),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag),
    .ldc_valid (ldc_valid),
    .ldc_tag   (ldc_tag),
    .rdy       (rdy),
    .mem_wait  (mem_wait)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    slq_fifo #(
      .WIDTH (UOP_W),
      .DEPTH (QDEPTH)
    ) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .push       (q_push[q]),
      .push_data  (disp_uop),
      .pop        (q_pop[q]),
      .head_valid (q_hvalid[q]),
      .head_data  (q_hdata[q]),
      .full       (q_full[q])
    );

    slq_port #(
      .NUM_REGS (NUM_REGS),
      .TAG_W    (TAG_W)
    ) u_port (
      .head_valid (q_hvalid[q]),
      .head_src0  (q_hdata[q][S0_LO +: TAG_W]),
      .head_src1  (q_hdata[q][S1_LO +: TAG_W]),
      .rdy        (rdy),
      .port_ready (q_prdy[q]),
      .iss_valid  (q_iss[q]),
      .pop        (q_pop[q])
    );

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (q_iss[q] && !q_prdy[q] && !flush) |=> (q_iss[q] && $stable(q_hdata[q]))); // R10
  end

  assign ind_valid   = q_iss[Q_IND];
  assign ind_src0    = q_hdata[Q_IND][S0_LO +: TAG_W];
  assign ind_src1    = q_hdata[Q_IND][S1_LO +: TAG_W];
  assign ind_dst     = q_hdata[Q_IND][DS_LO +: TAG_W];
  assign ind_is_load = q_hdata[Q_IND][LD_B];
  assign ind_slice   = q_hdata[Q_IND][SL_B];

  assign dep_valid   = q_iss[Q_DEP];
  assign dep_src0    = q_hdata[Q_DEP][S0_LO +: TAG_W];
  assign dep_src1    = q_hdata[Q_DEP][S1_LO +: TAG_W];
  assign dep_dst     = q_hdata[Q_DEP][DS_LO +: TAG_W];
  assign dep_is_load = q_hdata[Q_DEP][LD_B];
  assign dep_slice   = q_hdata[Q_DEP][SL_B];

  AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_push)); // R2
  AST_NO_DISPATCH_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (q_push == '0)); // R9

endmodule

// File: tb/slice_issue_unit_test.sv
module slice_issue_unit_test;

  logic clk = 1'b0;
  logic rst_n;
  logic flush;
  logic disp_valid, disp_ready, disp_is_load, disp_slice;
  logic [4:0] disp_src0, disp_src1, disp_dst;
  logic wb_valid, ldc_valid;
  logic [4:0] wb_tag, ldc_tag;
  logic ind_valid, ind_ready, ind_is_load, ind_slice;
  logic [4:0] ind_src0, ind_src1, ind_dst;
  logic dep_valid, dep_ready, dep_is_load, dep_slice;
  logic [4:0] dep_src0, dep_src1, dep_dst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slice_issue_unit uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_src0(disp_src0), .disp_src1(disp_src1), .disp_dst(disp_dst),
    .disp_is_load(disp_is_load), .disp_slice(disp_slice),
    .wb_valid(wb_valid), .wb_tag(wb_tag),
    .ldc_valid(ldc_valid), .ldc_tag(ldc_tag),
    .ind_valid(ind_valid), .ind_ready(ind_ready),
    .ind_src0(ind_src0), .ind_src1(ind_src1), .ind_dst(ind_dst),
    .ind_is_load(ind_is_load), .ind_slice(ind_slice),
    .dep_valid(dep_valid), .dep_ready(dep_ready),
    .dep_src0(dep_src0), .dep_src1(dep_src1), .dep_dst(dep_dst),
    .dep_is_load(dep_is_load), .dep_slice(dep_slice)
  );

  typedef struct packed {
    logic       dv;
    logic [4:0] s0, s1, dst;
    logic       ld, sl;
    logic       wbv;
    logic [4:0] wbt;
    logic       ldv;
    logic [4:0] ldt;
    logic       eiv;
    logic [4:0] eid;
    logic       eis;
    logic       edv;
    logic [4:0] edd;
    logic       eds;
  } vec_t;

  // Both ports always ready during the table walk
  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 5'd2, 5'd3, 5'd1, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd1, 1'b1, 1'b0, 5'd0, 1'b0},
    '{1'b1, 5'd1, 5'd2, 5'd4, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0},
    '{1'b1, 5'd2, 5'd3, 5'd5, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd5, 1'b0, 1'b0, 5'd0, 1'b0},
    '{1'b1, 5'd4, 5'd0, 5'd6, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0},
    '{1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 5'd1, 1'b0, 5'd0, 1'b0, 1'b1, 5'd4, 1'b1},
    '{1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd4, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd6, 1'b1},
    '{1'b1, 5'd1, 5'd4, 5'd7, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd7, 1'b0, 1'b0, 5'd0, 1'b0},
    '{1'b1, 5'd6, 5'd2, 5'd8, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0},
    '{1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd6, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd8, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 1'b0; disp_src0 = '0; disp_src1 = '0; disp_dst = '0;
    disp_is_load = 1'b0; disp_slice = 1'b0;
    wb_valid = 1'b0; wb_tag = '0; ldc_valid = 1'b0; ldc_tag = '0;
    flush = 1'b0;
  endtask

  task automatic drive(input logic [4:0] s0, input logic [4:0] s1,
                       input logic [4:0] dst, input logic ld);
    disp_valid = 1'b1; disp_src0 = s0; disp_src1 = s1; disp_dst = dst;
    disp_is_load = ld; disp_slice = 1'b0;
  endtask

  // Drive at negedge, let one edge pass, return at the next negedge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    ind_ready = 1'b1; dep_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 disp_ready", disp_ready, 1);
    chk("R1 ind_valid", ind_valid, 0);
    chk("R1 dep_valid", dep_valid, 0);

    // Table walk: R2 R3 R4 R6 steering, dependence and wakeup
    for (int i = 0; i < NVEC; i++) begin
      disp_valid = VEC[i].dv; disp_src0 = VEC[i].s0; disp_src1 = VEC[i].s1;
      disp_dst = VEC[i].dst; disp_is_load = VEC[i].ld; disp_slice = VEC[i].sl;
      wb_valid = VEC[i].wbv; wb_tag = VEC[i].wbt;
      ldc_valid = VEC[i].ldv; ldc_tag = VEC[i].ldt;
      cyc();
      chk($sformatf("R2/R6 step %0d ind_valid", i), ind_valid, VEC[i].eiv);
      chk($sformatf("R3/R4 step %0d dep_valid", i), dep_valid, VEC[i].edv);
      if (VEC[i].eiv) begin
        chk($sformatf("R2 step %0d ind_dst", i), ind_dst, VEC[i].eid);
        chk($sformatf("R10 step %0d ind_slice", i), ind_slice, VEC[i].eis);
      end
      if (VEC[i].edv) begin
        chk($sformatf("R4 step %0d dep_dst", i), dep_dst, VEC[i].edd);
        chk($sformatf("R10 step %0d dep_slice", i), dep_slice, VEC[i].eds);
      end
    end
    cyc();

    // R7 and R10: both heads issuable together, held while stalled
    ind_ready = 1'b0; dep_ready = 1'b0;
    drive(5'd2, 5'd3, 5'd10, 1'b1); cyc();
    drive(5'd10, 5'd2, 5'd11, 1'b0); cyc();
    ldc_valid = 1'b1; ldc_tag = 5'd10; cyc();
    chk("R7 ind_valid", ind_valid, 1);
    chk("R7 dep_valid", dep_valid, 1);
    chk("R10 ind_is_load", ind_is_load, 1);
    chk("R10 dep_src0", dep_src0, 10);
    cyc();
    chk("R10 ind held", ind_valid, 1);
    chk("R10 ind_dst held", ind_dst, 10);
    chk("R10 dep_dst held", dep_dst, 11);
    ind_ready = 1'b1; dep_ready = 1'b1;
    cyc();
    chk("R7 ind popped", ind_valid, 0);
    chk("R7 dep popped", dep_valid, 0);

    // R5 program order inside one queue
    ind_ready = 1'b0;
    drive(5'd2, 5'd3, 5'd12, 1'b0); cyc();
    drive(5'd2, 5'd3, 5'd13, 1'b0); cyc();
    drive(5'd2, 5'd3, 5'd14, 1'b0); cyc();
    ind_ready = 1'b1;
    chk("R5 first", ind_dst, 12);
    cyc();
    chk("R5 second", ind_dst, 13);
    cyc();
    chk("R5 third", ind_dst, 14);
    cyc();
    chk("R5 drained", ind_valid, 0);

    // R8 full target queue blocks, other queue still accepts
    ind_ready = 1'b0; dep_ready = 1'b0;
    drive(5'd2, 5'd3, 5'd16, 1'b1); #1;
    chk("R8 accept 0", disp_ready, 1);
    cyc();
    for (int k = 1; k < 8; k++) begin
      drive(5'd2, 5'd3, 5'(16 + k), 1'b0); #1;
      chk($sformatf("R8 accept %0d", k), disp_ready, 1);
      cyc();
    end
    drive(5'd16, 5'd2, 5'd24, 1'b0); #1;
    chk("R8 other queue open", disp_ready, 1);
    cyc();
    drive(5'd2, 5'd3, 5'd25, 1'b0); #1;
    chk("R8 full blocks", disp_ready, 0);
    cyc();
    chk("R8 head unchanged", ind_dst, 16);

    // R9 flush
    drive(5'd2, 5'd3, 5'd26, 1'b0); flush = 1'b1; #1;
    chk("R9 ready low in flush", disp_ready, 0);
    cyc();
    ind_ready = 1'b1; dep_ready = 1'b1; #1;
    chk("R9 ind empty", ind_valid, 0);
    chk("R9 dep empty", dep_valid, 0);
    ind_ready = 1'b0; dep_ready = 1'b0;
    // Waits-on-memory bit of 16 cleared: these fill the independent queue
    for (int k = 0; k < 8; k++) begin
      drive(5'd16, 5'd16, 5'(24 + k), 1'b0); cyc();
    end
    drive(5'd2, 5'd3, 5'd9, 1'b0); #1;
    chk("R9 wait bits cleared", disp_ready, 0);
    cyc();
    flush = 1'b1; cyc();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule